// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block feeds a transmit path from a ring of descriptors that software places in shared memory. Each descriptor takes two 32-bit words. The first word carries a byte count and a set of flags. The second word carries the byte address of a data buffer. Software fills in descriptors, marks them ready, and pulses a start strobe. If the MAC enable input is high, the walker then reads each ready descriptor in turn and streams the buffer's bytes out one per cycle. It hands the descriptor back to software by clearing its ready flag in memory, and it moves on until it reaches a descriptor that is not ready.

A frame may be spread over several buffers. The flag on the final buffer closes the frame. A wrap flag sends the walk back to a ring base that software programs. A frame that would grow past the configured maximum size is cut short, and a babble event is raised. Memory is one word-wide port with a fixed read latency of one cycle: read data is valid in the cycle after the request.

Top module: `txd_ring_engine`

## Requirements
- R1: The first word of a descriptor (at the current pointer) holds the byte count in bits 15:0 and the flags in bits 31:16: ready is bit 31, wrap is bit 29, last is bit 27. The second word (pointer + 4) holds the buffer byte address, which may be unaligned. Buffer bytes leave on `tx_data` one per `tx_valid` cycle, in ascending address order, with byte k of a memory word taken from bits 8k+7:8k.
- R2: After a descriptor is handled, the pointer advances by 8 bytes. If the descriptor's wrap flag is set, the pointer returns to the ring base instead.
- R3: Once a descriptor's buffer is consumed, its first word is written back to the same address with only bit 31 cleared.
- R4: A walk ends at the first descriptor whose ready flag is clear, and the pointer stays on that descriptor. The next walk begins there.
- R5: Every consumed descriptor pulses `ev_txb` in its write-back cycle. A descriptor with the last flag also pulses `ev_txf`, marks its final byte with `tx_last`, and resets the frame byte count to zero.
- R6: If the frame byte count plus a descriptor's byte count would exceed MAX_FRAME, only the bytes that still fit are sent, and `ev_babt` pulses with that descriptor's `ev_txb`.
- R7: Writing the ring base clears address bits 1:0 and also loads the current pointer with the new base.
- R8: The start strobe has no effect while `mac_en` is low: no memory access follows.
- R9: A start strobe accepted while a walk is in progress is remembered, and it starts a new walk from the current pointer once the present walk ends.
- R10: A descriptor whose effective byte count is zero (either programmed as zero, or clipped to zero by R6) sends no bytes but is still written back and still raises its events.
- R11: After reset there are no memory requests, no `tx_valid`, no events, and the pointer and ring base are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_en | input | 1 | MAC enable; the start strobe is honoured only while this is high |
| go_strobe | input | 1 | One-cycle pulse asking for a descriptor walk |
| base_wr | input | 1 | Write strobe for the ring base |
| base_data | input | AW | New ring base byte address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | High for a write, low for a read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tx_valid | output | 1 | Byte valid on tx_data |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of a frame |
| ev_txb | output | 1 | Pulse: one descriptor consumed |
| ev_txf | output | 1 | Pulse: frame finished |
| ev_babt | output | 1 | Pulse: frame cut short at the maximum size |

## Verification
The bench covers several descriptor patterns:
- A three-buffer frame that begins at an unaligned address and ends on a wrap flag. This separates byte-lane selection, gathering and ring return.
- A zero-length closing buffer, which isolates write-back and events from byte output.
- A run of buffers that overflows the maximum size, once with a partial clip and once clipped to nothing. This shows whether the byte count resets at frame end.
- Strobes given with the enable low, and a strobe given exactly when the walker has just seen a descriptor that is not ready. These tell an ignored strobe apart from a remembered one.
- A base written with its low bits set, which shows the alignment mask and the pointer reload.

// File: rtl/txd_pkg.sv
package txd_pkg;
  // flag positions inside the 16-bit flag half of descriptor word 0
  localparam int FLAG_READY = 15;
  localparam int FLAG_WRAP  = 13;
  localparam int FLAG_LAST  = 11;
  localparam int FLAG_BASE  = 16;
  localparam int DESC_STEP  = 8;
  localparam int WORD_W     = 32;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RDW0,
    S_GETW0,
    S_RDW1,
    S_GETW1,
    S_FETCH,
    S_LOAD,
    S_EMIT,
    S_WBACK
  } walk_state_t;
endpackage

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [AW-1:0] base_data,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] STEP  = AW'(txd_pkg::DESC_STEP);
  localparam logic [AW-1:0] ALIGN = ~AW'(3);

  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    base_d = base_q;
    ptr_d  = ptr_q;
    if (base_wr) begin
      base_d = base_data & ALIGN;
      ptr_d  = base_data & ALIGN;
    end else if (adv) begin
      ptr_d = wrap ? base_q : ptr_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else begin
      base_q <= base_d;
      ptr_q  <= ptr_d;
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/txd_frame_acct.sv
module txd_frame_acct #(
  parameter int MAX_FRAME = 2048,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len_in,
  input  logic             commit,
  input  logic             last,
  output logic [LEN_W-1:0] eff_len,
  output logic             clipped
);
  localparam int CW = $clog2(MAX_FRAME + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [31:0]   room;

  always_comb begin
    room = 32'(MAX_FRAME) - 32'(cnt_q);
    if (32'(len_in) > room) begin
      eff_len = LEN_W'(room);
      clipped = 1'b1;
    end else begin
      eff_len = len_in;
      clipped = 1'b0;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (commit) cnt_d = last ? '0 : cnt_q + CW'(eff_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine #(
  parameter int AW        = 32,
  parameter int MAX_FRAME = 2048,
  parameter int LEN_W     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mac_en,
  input  logic          go_strobe,
  input  logic          base_wr,
  input  logic [AW-1:0] base_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          ev_txb,
  output logic          ev_txf,
  output logic          ev_babt
);
  import txd_pkg::*;

  localparam int RDY_BIT = FLAG_BASE + FLAG_READY;
  localparam int WRP_BIT = FLAG_BASE + FLAG_WRAP;
  localparam int LST_BIT = FLAG_BASE + FLAG_LAST;
  localparam logic [AW-1:0]    WORD1_OFS = AW'(4);
  localparam logic [LEN_W-1:0] ONE       = LEN_W'(1);

  walk_state_t      st_q, st_d;
  logic             pend_q, pend_d;
  logic [31:0]      w0_q, w0_d;
  logic [AW-1:0]    ba_q, ba_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [31:0]      word_q, word_d;
  logic             clip_q, clip_d;

  logic             accept, adv, desc_last, clipped;
  logic [LEN_W-1:0] eff_len;
  logic [AW-1:0]    ptr;

  assign accept    = go_strobe & mac_en;
  assign desc_last = w0_q[LST_BIT];

  txd_ring_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_data(base_data),
    .adv(adv), .wrap(w0_q[WRP_BIT]), .ptr(ptr)
  );

  txd_frame_acct #(.MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W)) u_acct (
    .clk(clk), .rst_n(rst_n), .len_in(w0_q[LEN_W-1:0]),
    .commit(st_q == S_WBACK), .last(desc_last),
    .eff_len(eff_len), .clipped(clipped)
  );

  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q | ((st_q != S_IDLE) & accept);
    w0_d      = w0_q;
    ba_d      = ba_q;
    rem_d     = rem_q;
    word_d    = word_q;
    clip_d    = clip_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_wdata = '0;
    tx_valid  = 1'b0;
    tx_data   = '0;
    tx_last   = 1'b0;
    ev_txb    = 1'b0;
    ev_txf    = 1'b0;
    ev_babt   = 1'b0;
    adv       = 1'b0;
    case (st_q)
      S_IDLE: if (accept) st_d = S_RDW0;
      S_RDW0: begin
        mem_req = 1'b1;
        st_d    = S_GETW0;
      end
      S_GETW0: begin
        w0_d = mem_rdata;
        if (mem_rdata[RDY_BIT]) begin
          st_d = S_RDW1;
        end else begin
          st_d   = (pend_q | accept) ? S_RDW0 : S_IDLE;
          pend_d = 1'b0;
        end
      end
      S_RDW1: begin
        mem_req  = 1'b1;
        mem_addr = ptr + WORD1_OFS;
        st_d     = S_GETW1;
      end
      S_GETW1: begin
        ba_d   = mem_rdata[AW-1:0];
        rem_d  = eff_len;
        clip_d = clipped;
        st_d   = (eff_len == '0) ? S_WBACK : S_FETCH;
      end
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = {ba_q[AW-1:2], 2'b00};
        st_d     = S_LOAD;
      end
      S_LOAD: begin
        word_d = mem_rdata;
        st_d   = S_EMIT;
      end
      S_EMIT: begin
        tx_valid = 1'b1;
        tx_data  = word_q[{ba_q[1:0], 3'b000} +: 8];
        tx_last  = (rem_q == ONE) & desc_last;
        ba_d     = ba_q + AW'(1);
        rem_d    = rem_q - ONE;
        if (rem_q == ONE)          st_d = S_WBACK;
        else if (ba_q[1:0] == 2'd3) st_d = S_FETCH;
      end
      S_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = w0_q & ~(32'd1 << RDY_BIT);
        ev_txb    = 1'b1;
        ev_txf    = desc_last;
        ev_babt   = clip_q;
        adv       = 1'b1;
        st_d      = S_RDW0;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pend_q <= 1'b0;
      w0_q   <= '0;
      ba_q   <= '0;
      rem_q  <= '0;
      word_q <= '0;
      clip_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      w0_q   <= w0_d;
      ba_q   <= ba_d;
      rem_q  <= rem_d;
      word_q <= word_d;
      clip_q <= clip_d;
    end
  end
endmodule

// File: rtl/txd_ring_chk.sv
module txd_ring_chk #(
  parameter int MAX_FRAME = 2048
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_req,
  input logic       mem_we,
  input logic [1:0] addr_lo,
  input logic       wb_ready,
  input logic       tx_valid,
  input logic       tx_last,
  input logic       ev_txb,
  input logic       ev_txf,
  input logic       ev_babt
);
  logic [31:0] fbytes_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fbytes_q <= '0;
    else if (ev_txf)   fbytes_q <= '0;
    else if (tx_valid) fbytes_q <= fbytes_q + 32'd1;
  end

  assert_last_with_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  assert_frame_implies_buf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txf |-> ev_txb);

  assert_babble_implies_buf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_babt |-> ev_txb);

  assert_frame_within_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fbytes_q <= 32'(MAX_FRAME));

  assert_wback_clears_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (!wb_ready && addr_lo == 2'b00 && ev_txb));

  assert_event_only_on_wback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txb |-> (mem_req && mem_we));

  assert_word_aligned_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (addr_lo == 2'b00 && !tx_valid));

  assert_write_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
endmodule

bind txd_ring_engine txd_ring_chk #(.MAX_FRAME(MAX_FRAME)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .addr_lo(mem_addr[1:0]), .wb_ready(mem_wdata[31]),
  .tx_valid(tx_valid), .tx_last(tx_last),
  .ev_txb(ev_txb), .ev_txf(ev_txf), .ev_babt(ev_babt)
);

// File: tb/txd_ring_engine_test.sv
module txd_ring_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXF       = 40;
  localparam int WDOG       = 20000;
  localparam logic [15:0] RDY = 16'h8000;
  localparam logic [15:0] WRP = 16'h2000;
  localparam logic [15:0] LST = 16'h0800;

  logic clk, rst_n, mac_en, go_strobe, base_wr;
  logic [31:0] base_data;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, rdata;
  logic tx_valid, tx_last, ev_txb, ev_txf, ev_babt;
  logic [7:0] tx_data;

  txd_ring_engine #(.AW(32), .MAX_FRAME(MAXF), .LEN_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .go_strobe(go_strobe),
    .base_wr(base_wr), .base_data(base_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .ev_txb(ev_txb), .ev_txf(ev_txf), .ev_babt(ev_babt)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: 256 words, one-cycle read latency
  logic [31:0] mem [0:255];
  logic        tb_wr;
  logic [31:0] tb_addr, tb_wdata;

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 7 + 3) & 255);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++)
        mem[i] <= (i < 128) ? 32'd0 : {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
    end else begin
      if (mem_req && mem_we)  mem[mem_addr[9:2]] <= mem_wdata;
      if (mem_req && !mem_we) rdata <= mem[mem_addr[9:2]];
      if (tb_wr)              mem[tb_addr[9:2]] <= tb_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_ptr, m_base, m_fcnt;
  logic [8:0]  exp_tx[$];
  int          exp_wa[$];
  logic [31:0] exp_wd[$];
  logic [2:0]  exp_ev[$];

  task automatic model_walk();
    logic [31:0] img [0:255];
    for (int i = 0; i < 256; i++) img[i] = mem[i];
    for (int g = 0; g < 64; g++) begin
      logic [31:0] w0, ba;
      int len;
      bit clip, lst;
      w0 = img[(m_ptr >> 2) & 255];
      if (!w0[31]) break;
      ba   = img[((m_ptr + 4) >> 2) & 255];
      len  = int'(w0[15:0]);
      lst  = w0[27];
      clip = 0;
      if (m_fcnt + len > MAXF) begin
        len  = MAXF - m_fcnt;
        clip = 1;
      end
      for (int i = 0; i < len; i++) begin
        int a;
        logic [31:0] w;
        a = int'(ba) + i;
        w = img[(a >> 2) & 255];
        exp_tx.push_back({lst && (i == len - 1), w[8*(a & 3) +: 8]});
      end
      m_fcnt = lst ? 0 : m_fcnt + len;
      exp_wa.push_back(m_ptr);
      exp_wd.push_back(w0 & 32'h7fff_ffff);
      exp_ev.push_back({1'b1, lst, clip});
      img[(m_ptr >> 2) & 255] = w0 & 32'h7fff_ffff;
      m_ptr = w0[29] ? m_base : m_ptr + 8;
    end
  endtask

  // per-clock comparison against the model
  int rd_count;
  int rd_first;
  bit rd_arm;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_req && !mem_we) begin
        rd_count++;
        if (rd_arm) begin rd_first = int'(mem_addr); rd_arm = 0; end
      end
      if (tx_valid) begin
        if (exp_tx.size() == 0) chk(0, "R1 unexpected byte", {55'd0, tx_last, tx_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_tx.pop_front();
          chk({tx_last, tx_data} == e, "R1/R5 byte and last", {55'd0, tx_last, tx_data}, {55'd0, e});
        end
      end else begin
        chk(!tx_last, "R5 tx_last without byte", tx_last, 0);
      end
      if (mem_req && mem_we) begin
        if (exp_wa.size() == 0) chk(0, "R3 unexpected write-back", mem_addr, 0);
        else begin
          int ea;
          logic [31:0] ed;
          ea = exp_wa.pop_front();
          ed = exp_wd.pop_front();
          chk(int'(mem_addr) == ea, "R2 write-back address", mem_addr, ea);
          chk(mem_wdata == ed, "R3 write-back data", mem_wdata, ed);
        end
      end
      if (ev_txb || ev_txf || ev_babt) begin
        if (exp_ev.size() == 0) chk(0, "R5 unexpected event", {ev_txb, ev_txf, ev_babt}, 0);
        else begin
          logic [2:0] ee;
          ee = exp_ev.pop_front();
          chk({ev_txb, ev_txf, ev_babt} == ee, "R5/R6 events", {ev_txb, ev_txf, ev_babt}, ee);
        end
      end
    end
  end

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    tb_wr = 1; tb_addr = a; tb_wdata = d;
    @(negedge clk);
    tb_wr = 0;
  endtask

  task automatic put_desc(input int a, input logic [15:0] fl, input logic [15:0] len, input int bufa);
    poke(a, {fl, len});
    poke(a + 4, bufa);
  endtask

  task automatic set_base(input logic [31:0] v);
    @(negedge clk);
    base_wr = 1; base_data = v;
    @(negedge clk);
    base_wr = 0;
    m_base = int'(v & ~32'd3);
    m_ptr  = m_base;
  endtask

  task automatic strobe();
    @(negedge clk);
    go_strobe = 1;
    @(negedge clk);
    go_strobe = 0;
  endtask

  task automatic settle(input string tag);
    repeat (300) @(negedge clk);
    chk(exp_tx.size() == 0, tag, exp_tx.size(), 0);
    chk(exp_wa.size() == 0, tag, exp_wa.size(), 0);
    chk(exp_ev.size() == 0, tag, exp_ev.size(), 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; mac_en = 0; go_strobe = 0; base_wr = 0; base_data = 0;
    tb_wr = 0; tb_addr = 0; tb_wdata = 0;
    m_ptr = 0; m_base = 0; m_fcnt = 0; rd_count = 0; rd_first = -1; rd_arm = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: quiet after reset
    chk(!mem_req && !tx_valid, "R11 reset outputs", {mem_req, tx_valid}, 0);
    chk(!ev_txb && !ev_txf && !ev_babt, "R11 reset events", {ev_txb, ev_txf, ev_babt}, 0);
    mac_en = 1;

    // R11: pointer is zero after reset (descriptor at 0 read first)
    put_desc(32'h0, RDY | LST, 16'd2, 32'h200);
    rd_arm = 1;
    model_walk();
    strobe();
    settle("R11 walk from zero");
    chk(rd_first == 0, "R11 first read at zero", rd_first, 0);

    // S1: R1 R2 gather over three buffers, unaligned start, wrap to base
    set_base(32'h40);
    put_desc(32'h40, RDY,             16'd5, 32'h201);
    put_desc(32'h48, RDY,             16'd3, 32'h210);
    put_desc(32'h50, RDY | LST | WRP, 16'd6, 32'h223);
    model_walk();
    strobe();
    settle("R2 gather and wrap drained");

    // S2: R4 resume at kept pointer, R10 zero-length last buffer
    put_desc(32'h40, RDY | LST, 16'd0, 32'h230);
    rd_arm = 1;
    model_walk();
    strobe();
    settle("R10 zero length drained");
    chk(rd_first == 32'h40, "R4 resume at kept pointer", rd_first, 32'h40);

    // S3: R6 babble, partial clip then clip to zero
    put_desc(32'h48, RDY,       16'd30, 32'h300);
    put_desc(32'h50, RDY | LST, 16'd25, 32'h305);
    put_desc(32'h58, RDY | LST, 16'd4,  32'h302);
    put_desc(32'h60, RDY,       16'd40, 32'h300);
    put_desc(32'h68, RDY | LST, 16'd3,  32'h300);
    model_walk();
    strobe();
    settle("R6 clip drained");

    // S4: R8 strobe ignored while disabled
    put_desc(32'h70, RDY | LST, 16'd2, 32'h240);
    mac_en = 0;
    rd_count = 0;
    strobe();
    repeat (40) @(negedge clk);
    chk(rd_count == 0, "R8 no access while disabled", rd_count, 0);
    chk(mem[32'h70 >> 2][31] == 1'b1, "R8 descriptor untouched", mem[32'h70 >> 2], {RDY | LST, 16'd2});
    mac_en = 1;
    model_walk();
    strobe();
    settle("R8 enabled walk drained");

    // S5: R9 strobe latched while the walker sees a not-ready descriptor
    put_desc(32'h78, RDY | LST, 16'd12, 32'h250);
    put_desc(32'h80, 16'h0,     16'd2,  32'h264);
    model_walk();
    strobe();
    begin
      bit seen;
      seen = 0;
      for (int g = 0; g < 200 && !seen; g++) begin
        @(negedge clk);
        if (mem_req && !mem_we && mem_addr == 32'h80) seen = 1;
      end
      chk(seen, "R9 walker reached not-ready descriptor", seen, 1);
      @(negedge clk);
      tb_wr = 1; tb_addr = 32'h80; tb_wdata = {RDY | LST, 16'd2};
      go_strobe = 1;
      @(negedge clk);
      tb_wr = 0; go_strobe = 0;
      model_walk();
    end
    settle("R9 latched walk drained");

    // S6: R7 base low bits masked and pointer reloaded, R2 wrap to it
    set_base(32'h103);
    put_desc(32'h100, RDY | LST | WRP, 16'd3, 32'h2f1);
    rd_arm = 1;
    model_walk();
    strobe();
    settle("R7 walk drained");
    chk(rd_first == 32'h100, "R7 pointer reloaded to masked base", rd_first, 32'h100);
    put_desc(32'h100, RDY | LST | WRP, 16'd1, 32'h2f8);
    rd_arm = 1;
    model_walk();
    strobe();
    settle("R2 second wrap drained");
    chk(rd_first == 32'h100, "R2 wrap returned to base", rd_first, 32'h100);

    finish_run();
  end
endmodule